// File: doc/BRIEF.md
# SD Bus DAT1 Inter-Block Interrupt Monitor

This block sits on the host side of a 4-bit SD/SDIO bus and watches the DAT1 line during multi-block reads and writes. Between two data blocks a card may signal an interrupt in a gap that lasts two SD clocks. It drives DAT1 low on the first clock and high on the second, then releases the line. The monitor opens that gap when the data path reports the end of a block. It samples DAT1 only on SD clock enable strobes and tells a correct interrupt pattern apart from a malformed one.

A correct pattern gives a one-cycle interrupt pulse and sets a sticky status bit. Software or a controller clears that bit through a clear input. A first clock that is low followed by a second clock that is not driven high gives a one-cycle protocol-error pulse. A start-of-block strobe inside the gap cancels it. In 1-bit mode or for single-block transfers the monitor stays idle.

Top module: `sdio_d1_irq_mon`

## Requirements
- R1: The gap logic is active only while `bus_wide4` and `xfer_multi` are both 1. Otherwise the monitor is idle and `irq_pulse` and `proto_err` stay 0.
- R2: The gap starts at the first cycle with `sd_tick`=1 after a cycle with `blk_done`=1. DAT1 is evaluated only in cycles with `sd_tick`=1, and its level in other cycles has no effect.
- R3: The first gap sample must be driven low (`dat1_drv`=1, `dat1_in`=0). If it is high or undriven, the gap closes with no pulse of either kind.
- R4: A driven-high second sample (`dat1_drv`=1, `dat1_in`=1) after a valid first sample makes `irq_pulse` 1 for exactly one clock. That clock is the cycle after the second sample's `sd_tick` cycle.
- R5: A second sample that is low or undriven after a valid first sample makes `proto_err` 1 for one clock, at the same time R4 would apply, and `irq_pulse` stays 0.
- R6: After the second sample the monitor returns to idle. Further DAT1 activity is ignored until the next `blk_done`.
- R7: `blk_begin`=1 while a gap is open closes the gap without any pulse.
- R8: `irq_flag` rises together with `irq_pulse` and stays 1 until a cycle with `irq_clr`=1. A clear in the same cycle as a detection leaves it 1.
- R9: Synchronous `rst`=1 returns the monitor to idle with `irq_pulse`, `proto_err` and `irq_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_tick | input | 1 | One-cycle strobe marking an SD clock sampling edge |
| dat1_in | input | 1 | Sampled DAT1 level |
| dat1_drv | input | 1 | 1 when the card is driving DAT1 |
| bus_wide4 | input | 1 | 1 when the bus is in 4-bit mode |
| xfer_multi | input | 1 | 1 for a multi-block transfer |
| blk_done | input | 1 | End-of-block strobe from the data path |
| blk_begin | input | 1 | Start-of-block strobe from the data path |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| irq_pulse | output | 1 | One-cycle card interrupt indication |
| proto_err | output | 1 | One-cycle malformed-gap indication |
| irq_flag | output | 1 | Sticky interrupt status |

## Verification
The assertions check four things on every cycle. The gap state falls back to idle whenever the mode is not 4-bit multi-block. A detection or error never comes from a cycle without an SD clock strobe. The interrupt and error pulses last one clock and never occur together. The sticky flag holds until it is cleared. Only the bench's scenarios can show that a particular DAT1 sequence gives the right outcome. It sweeps every mode, every first and second sample kind and every abort point. It also covers the ignored activity after a gap, reset inside an open gap, and a clear that collides with a detection.

// File: rtl/sdio_d1_irq_pkg.sv
package sdio_d1_irq_pkg;

    typedef enum logic [1:0] {
        GAP_IDLE   = 2'd0,
        GAP_FIRST  = 2'd1,
        GAP_SECOND = 2'd2
    } gap_state_e;

    typedef struct packed {
        gap_state_e st;
    } gap_regs_t;

    typedef struct packed {
        logic pulse;
        logic err;
        logic flag;
    } flag_regs_t;

endpackage

// File: rtl/sdio_d1_gap_fsm.sv
module sdio_d1_gap_fsm
    import sdio_d1_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       gate_on,
    input  logic       sd_tick,
    input  logic       blk_done,
    input  logic       blk_begin,
    input  logic       d1_low,
    input  logic       d1_high,
    output logic       hit,
    output logic       fault,
    output gap_state_e state_o
);

    gap_regs_t q, d;

    always_comb begin
        d     = q;
        hit   = 1'b0;
        fault = 1'b0;
        if (!gate_on) begin
            d.st = GAP_IDLE;
        end else begin
            case (q.st)
                GAP_IDLE: begin
                    if (blk_done) d.st = GAP_FIRST;
                end
                GAP_FIRST: begin
                    if (blk_begin)    d.st = GAP_IDLE;
                    else if (sd_tick) d.st = d1_low ? GAP_SECOND : GAP_IDLE;
                end
                GAP_SECOND: begin
                    if (blk_begin) begin
                        d.st = GAP_IDLE;
                    end else if (sd_tick) begin
                        hit   = d1_high;
                        fault = !d1_high;
                        d.st  = GAP_IDLE;
                    end
                end
                default: d.st = GAP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{st: GAP_IDLE};
        else     q <= d;
    end

    assign state_o = q.st;

    // R1: leaving 4-bit multi-block mode forces idle
    a_r1_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !gate_on |=> (q.st == GAP_IDLE));

    // R2: no outcome without an SD clock strobe
    a_r2_tick_only: assert property (@(posedge clk) disable iff (rst)
        !sd_tick |-> (!hit && !fault));

    // R3: a first sample that is not driven low ends the gap
    a_r3_first_low: assert property (@(posedge clk) disable iff (rst)
        (gate_on && q.st == GAP_FIRST && sd_tick && !blk_begin && !d1_low)
        |=> (q.st == GAP_IDLE));

    // R7: start of block closes an open gap
    a_r7_abort: assert property (@(posedge clk) disable iff (rst)
        (q.st != GAP_IDLE && blk_begin) |-> (!hit && !fault) ##1 (q.st == GAP_IDLE));

endmodule

// File: rtl/sdio_d1_flag_reg.sv
module sdio_d1_flag_reg
    import sdio_d1_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic fault,
    input  logic clr,
    output logic pulse,
    output logic err,
    output logic flag
);

    flag_regs_t q, d;

    always_comb begin
        d.pulse = hit;
        d.err   = fault;
        d.flag  = (q.flag && !clr) || hit;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign pulse = q.pulse;
    assign err   = q.err;
    assign flag  = q.flag;

    // R4: interrupt pulse lasts a single clock
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R5: error and interrupt never together
    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pulse && err));

    // R8: flag accompanies every pulse
    a_r8_flag_with_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse |-> flag);

    // R8: flag holds until cleared
    a_r8_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/sdio_d1_irq_mon.sv
module sdio_d1_irq_mon
    import sdio_d1_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sd_tick,
    input  logic dat1_in,
    input  logic dat1_drv,
    input  logic bus_wide4,
    input  logic xfer_multi,
    input  logic blk_done,
    input  logic blk_begin,
    input  logic irq_clr,
    output logic irq_pulse,
    output logic proto_err,
    output logic irq_flag
);

    logic       gate_on;
    logic       d1_low;
    logic       d1_high;
    logic       hit;
    logic       fault;
    gap_state_e gap_st;

    assign gate_on = bus_wide4 && xfer_multi;
    assign d1_low  = dat1_drv && !dat1_in;
    assign d1_high = dat1_drv && dat1_in;

    sdio_d1_gap_fsm u_gap (
        .clk       (clk),
        .rst       (rst),
        .gate_on   (gate_on),
        .sd_tick   (sd_tick),
        .blk_done  (blk_done),
        .blk_begin (blk_begin),
        .d1_low    (d1_low),
        .d1_high   (d1_high),
        .hit       (hit),
        .fault     (fault),
        .state_o   (gap_st)
    );

    sdio_d1_flag_reg u_flag (
        .clk   (clk),
        .rst   (rst),
        .hit   (hit),
        .fault (fault),
        .clr   (irq_clr),
        .pulse (irq_pulse),
        .err   (proto_err),
        .flag  (irq_flag)
    );

    // R1: no indication follows a cycle outside 4-bit multi-block mode
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !gate_on |=> (!irq_pulse && !proto_err));

    // R6: an outcome leaves the gap state idle
    a_r6_back_to_idle: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse || proto_err) |-> (gap_st != GAP_SECOND));

endmodule

// File: tb/sdio_d1_irq_mon_tb.sv
module sdio_d1_irq_mon_tb;

    logic clk = 1'b0;
    logic rst, sd_tick, dat1_in, dat1_drv, bus_wide4, xfer_multi;
    logic blk_done, blk_begin, irq_clr;
    logic irq_pulse, proto_err, irq_flag;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    int err_cnt = 0;

    always #5 clk = ~clk;

    sdio_d1_irq_mon u_dut (
        .clk(clk), .rst(rst), .sd_tick(sd_tick), .dat1_in(dat1_in),
        .dat1_drv(dat1_drv), .bus_wide4(bus_wide4), .xfer_multi(xfer_multi),
        .blk_done(blk_done), .blk_begin(blk_begin), .irq_clr(irq_clr),
        .irq_pulse(irq_pulse), .proto_err(proto_err), .irq_flag(irq_flag)
    );

    always @(negedge clk) begin
        if (irq_pulse) irq_cnt++;
        if (proto_err) err_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        sd_tick = 0; blk_done = 0; blk_begin = 0; irq_clr = 0;
    endtask

    // kind: 0 driven low, 1 driven high, 2 undriven
    task automatic put(input int kind);
        dat1_drv = (kind != 2);
        dat1_in  = (kind == 1);
    endtask

    // garbage on DAT1 between strobes (R2)
    task automatic noise(input int kind);
        put(kind == 0 ? 0 : 1);
        dat1_in = !dat1_in; dat1_drv = 1;
        step();
        put(2); step();
    endtask

    task automatic scenario(input int w, input int m, input int f, input int s,
                            input int ab, input bit clr_first, input bit clr_hit);
        int exp_irq, exp_err;
        bus_wide4 = w[0]; xfer_multi = m[0];
        if (clr_first) begin irq_clr = 1; step(); end
        irq_cnt = 0; err_cnt = 0;
        blk_done = 1; put(1); step();
        noise(0);
        if (ab == 1) begin blk_begin = 1; step(); end
        sd_tick = 1; put(f); step();
        noise(f);
        if (ab == 2) begin blk_begin = 1; step(); end
        sd_tick = 1; put(s); irq_clr = clr_hit; step();
        step();
        // later activity must be ignored (R6)
        sd_tick = 1; put(0); step();
        sd_tick = 1; put(1); step();
        step();
        exp_irq = 0; exp_err = 0;
        if (w == 1 && m == 1 && ab == 0 && f == 0) begin
            if (s == 1) exp_irq = 1; else exp_err = 1;
        end
        check(exp_irq == 0 && w == 1 && m == 1 && ab == 0 ? "R3/R5" :
              (w == 0 || m == 0) ? "R1" : (ab != 0 ? "R7" : "R4"),
              irq_cnt, exp_irq);
        check(exp_err ? "R5" : "R6", err_cnt, exp_err);
        if (clr_first) check("R8", irq_flag, exp_irq);
    endtask

    initial begin
        rst = 1; sd_tick = 0; dat1_in = 1; dat1_drv = 0; bus_wide4 = 0;
        xfer_multi = 0; blk_done = 0; blk_begin = 0; irq_clr = 0;
        repeat (3) step();
        check("R9 pulse", irq_pulse, 0);
        check("R9 err", proto_err, 0);
        check("R9 flag", irq_flag, 0);
        rst = 0; step();

        for (int w = 0; w < 2; w++)
            for (int m = 0; m < 2; m++)
                for (int f = 0; f < 3; f++)
                    for (int s = 0; s < 3; s++)
                        for (int ab = 0; ab < 3; ab++)
                            scenario(w, m, f, s, ab, 1'b1, 1'b0);

        // R8: flag holds without clear, clear colliding with detection keeps it set
        scenario(1, 1, 0, 1, 0, 1'b1, 1'b0);
        repeat (5) step();
        check("R8 hold", irq_flag, 1);
        scenario(1, 1, 0, 1, 0, 1'b0, 1'b1);
        check("R8 clr+set", irq_flag, 1);
        check("R8 clr+set pulse", irq_cnt, 1);
        irq_clr = 1; step();
        check("R8 clear", irq_flag, 0);

        // R9: reset inside an open gap
        scenario(1, 1, 0, 1, 0, 1'b1, 1'b0);
        check("R9 flag before", irq_flag, 1);
        irq_cnt = 0;
        blk_done = 1; step();
        sd_tick = 1; put(0); step();
        rst = 1; step();
        check("R9 flag after", irq_flag, 0);
        rst = 0; step();
        sd_tick = 1; put(1); step();
        step(); step();
        check("R9 gap dropped", irq_cnt, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule